// File: doc/BRIEF.md
# Pre-encoded radix-4 signed-digit constant multiplier

This block multiplies a signed two's complement operand by one coefficient from a small fixed set (filter taps, a twiddle table and the like). The coefficients are held in an internal table that is already in radix-4 signed-digit form. The multiplier therefore has no recoding stage on chip. Each stored digit directly selects a partial product of 0, ±A or ±2A. The partial products are summed and the full-width product is registered.

Every digit below the top one is stored in 2 bits and takes one of four values. A build-time parameter picks one of two variants of this four-value set. The top digit is stored in 3 bits and uses the five-value Booth set, so a table word for a B_W-bit coefficient is B_W+1 bits wide. The table contents are derived from a fixed coefficient rule at elaboration. The caller presents an index and an operand with a valid strobe, and reads the product one clock later.

Top module: `rnsd_premul`

## Requirements
- R1: When `in_valid` is high at a rising edge, `product` at that edge becomes the exact signed product of `a` and coefficient `coef_idx`, A_W+B_W bits wide, for every table entry and every operand value.
- R2: `out_valid` is high for exactly the cycle after each cycle in which `in_valid` was sampled high, and is low otherwise.
- R3: When `in_valid` is low at an edge, `product` keeps its value, whatever `a` and `coef_idx` do.
- R4: While `rst_n` is low, `out_valid` is 0 and `product` is 0.
- R5: Table entry k holds this coefficient. For k=0 it is the most negative B_W-bit value. For k=1 it is the most positive value. For k=2 it is 0 and for k=3 it is -1. For k=4 it is the repeated bit pair 01, and for k=5 the repeated pair 10. For any other k it is the low B_W bits of k*40503+12345, read as signed.
- R6: With MINUS_SET=1, each lower 2-bit digit code means 00=0, 01=+1, 10=-2, 11=-1.
- R7: With MINUS_SET=0, each lower 2-bit digit code means 00=0, 01=+1, 10=+2, 11=-1. Products are exact for both variants.
- R8: The top digit is a 3-bit code {negate, double, single} with the legal values 000=0, 001=+1, 010=+2, 101=-1 and 110=-2. No other top code reaches the partial-product stage.
- R9: An operand equal to zero always gives a zero product. Both extremes of the operand range, including the most negative value times the most negative coefficient, give exact products.
- R10: A table word is B_W+1 bits: B_W/2-1 lower digits of 2 bits each, plus the 3-bit top digit in the highest bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and index valid; enables the product register |
| coef_idx | input | IDX_W | Coefficient table index |
| a | input | A_W | Signed operand |
| out_valid | output | 1 | Product valid, one cycle after `in_valid` |
| product | output | A_W+B_W | Signed product |

## Verification
On every cycle, the assertions check the valid timing, the holding of the product, the zero-operand result and the legality of the top-digit code read from the table. Only the bench's sweeps can show that the products are arithmetically exact. The bench runs every table entry against extreme and random operands, on one instance of each digit-set variant, and compares the results against a plain signed multiply of the coefficient rule.

// File: rtl/rnsd_pkg.sv
package rnsd_pkg;

  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } pp_sel_t;

  // lower digit: 00=0, 01=+1, 10=+/-2 by variant, 11=-1
  function automatic pp_sel_t dec_low(input logic [1:0] code, input logic minus_set);
    pp_sel_t s;
    s.two = (code == 2'b10);
    s.one = code[0];
    s.neg = (code == 2'b11) || (s.two && minus_set);
    return s;
  endfunction

  // top digit: {negate, double, single}
  function automatic pp_sel_t dec_top(input logic [2:0] code);
    pp_sel_t s;
    s.neg = code[2];
    s.two = code[1];
    s.one = code[0];
    return s;
  endfunction

endpackage

// File: rtl/rnsd_coef_rom.sv
module rnsd_coef_rom #(
  parameter int B_W       = 16,
  parameter int DEPTH     = 8,
  parameter bit MINUS_SET = 1'b1,
  localparam int NDIG     = B_W / 2,
  localparam int WORD_W   = B_W + 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);

  function automatic logic [B_W-1:0] coef_val(input int k);
    logic [B_W-1:0] c;
    c = '0;
    case (k)
      0: c = {1'b1, {(B_W-1){1'b0}}};
      1: c = {1'b0, {(B_W-1){1'b1}}};
      2: c = '0;
      3: c = '1;
      4: for (int i = 0; i < NDIG; i++) c[2*i +: 2] = 2'b01;
      5: for (int i = 0; i < NDIG; i++) c[2*i +: 2] = 2'b10;
      default: c = B_W'(k * 40503 + 12345);
    endcase
    return c;
  endfunction

  // build-time recoding, least significant digit first, carry in {0,1}
  function automatic logic [WORD_W-1:0] encode(input logic [B_W-1:0] b);
    logic [WORD_W-1:0] w;
    int cy, v, d, t;
    w  = '0;
    cy = 0;
    for (int i = 0; i < NDIG - 1; i++) begin
      v = int'(b[2*i +: 2]) + cy;
      if (MINUS_SET) begin
        if (v <= 1) begin d = v; cy = 0; end
        else begin d = v - 4; cy = 1; end
      end else begin
        if (v <= 2) begin d = v; cy = 0; end
        else begin d = v - 4; cy = 1; end
      end
      case (d)
        0:       w[2*i +: 2] = 2'b00;
        1:       w[2*i +: 2] = 2'b01;
        -1:      w[2*i +: 2] = 2'b11;
        default: w[2*i +: 2] = 2'b10;
      endcase
    end
    t = -2 * int'(b[B_W-1]) + int'(b[B_W-2]) + cy;
    case (t)
      1:       w[WORD_W-1 -: 3] = 3'b001;
      2:       w[WORD_W-1 -: 3] = 3'b010;
      -1:      w[WORD_W-1 -: 3] = 3'b101;
      -2:      w[WORD_W-1 -: 3] = 3'b110;
      default: w[WORD_W-1 -: 3] = 3'b000;
    endcase
    return w;
  endfunction

  logic [WORD_W-1:0] table_q [DEPTH];

  // R5 R10: one constant word per entry, B_W+1 bits
  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam logic [WORD_W-1:0] ENC = encode(coef_val(k));
    assign table_q[k] = ENC;
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < DEPTH; k++)
      if (idx == IDX_W'(k)) word = table_q[k];
  end

endmodule

// File: rtl/rnsd_pp_gen.sv
module rnsd_pp_gen
  import rnsd_pkg::*;
#(
  parameter int A_W       = 16,
  parameter int P_W       = 32,
  parameter int SHIFT     = 0,
  parameter bit IS_TOP    = 1'b0,
  parameter bit MINUS_SET = 1'b1
) (
  input  logic [A_W-1:0] a,
  input  logic [2:0]     code,
  output logic [P_W-1:0] pp
);

  pp_sel_t        sel;
  logic [P_W-1:0] a_ext;
  logic [P_W-1:0] mag;
  logic [P_W-1:0] sgn;

  // R8: top digit uses the Booth code; R6 R7: lower digits the variant set
  if (IS_TOP) begin : g_top
    assign sel = dec_top(code);
  end else begin : g_low
    assign sel = dec_low(code[1:0], MINUS_SET);
  end

  assign a_ext = {{(P_W-A_W){a[A_W-1]}}, a};

  always_comb begin
    if (sel.two)      mag = a_ext << 1;
    else if (sel.one) mag = a_ext;
    else              mag = '0;
    sgn = sel.neg ? (~mag + P_W'(1)) : mag;
    pp  = sgn << SHIFT;
  end

endmodule

// File: rtl/rnsd_premul.sv
module rnsd_premul #(
  parameter int A_W       = 16,
  parameter int B_W       = 16,
  parameter int DEPTH     = 8,
  parameter bit MINUS_SET = 1'b1,
  localparam int P_W      = A_W + B_W,
  localparam int NDIG     = B_W / 2,
  localparam int WORD_W   = B_W + 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] coef_idx,
  input  logic [A_W-1:0]   a,
  output logic             out_valid,
  output logic [P_W-1:0]   product
);

  logic [WORD_W-1:0] word;
  logic [P_W-1:0]    pp [NDIG];
  logic [P_W-1:0]    sum;
  logic [P_W-1:0]    prod_d, prod_q;
  logic              vld_d, vld_q;

  rnsd_coef_rom #(.B_W(B_W), .DEPTH(DEPTH), .MINUS_SET(MINUS_SET)) u_rom (
    .idx  (coef_idx),
    .word (word)
  );

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [2:0] dcode;
    if (i == NDIG - 1) begin : g_hi
      assign dcode = word[WORD_W-1 -: 3];
    end else begin : g_lo
      assign dcode = {1'b0, word[2*i +: 2]};
    end
    rnsd_pp_gen #(
      .A_W(A_W), .P_W(P_W), .SHIFT(2*i),
      .IS_TOP(i == NDIG - 1), .MINUS_SET(MINUS_SET)
    ) u_pp (
      .a    (a),
      .code (dcode),
      .pp   (pp[i])
    );
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NDIG; i++) sum = sum + pp[i];
  end

  // next state
  always_comb begin
    vld_d  = in_valid;
    prod_d = in_valid ? sum : prod_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      prod_q <= '0;
    end else begin
      vld_q  <= vld_d;
      prod_q <= prod_d;
    end
  end

  assign out_valid = vld_q;
  assign product   = prod_q;

  // R8
  top_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (word[WORD_W-2 -: 2] != 2'b11) &&
                 !(word[WORD_W-1] && word[WORD_W-2 -: 2] == 2'b00));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  // R9
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a == '0) |=> (product == '0));

endmodule

// File: tb/rnsd_premul_bench.sv
module rnsd_premul_bench;

  localparam int A_W   = 16;
  localparam int B_W   = 16;
  localparam int DEPTH = 8;
  localparam int P_W   = A_W + B_W;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [IDX_W-1:0] coef_idx = '0;
  logic [A_W-1:0]   a = '0;
  logic             ov_m, ov_p;
  logic [P_W-1:0]   pr_m, pr_p;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rnsd_premul #(.A_W(A_W), .B_W(B_W), .DEPTH(DEPTH), .MINUS_SET(1'b1)) u_rnsd_premul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coef_idx(coef_idx), .a(a),
    .out_valid(ov_m), .product(pr_m)
  );

  rnsd_premul #(.A_W(A_W), .B_W(B_W), .DEPTH(DEPTH), .MINUS_SET(1'b0)) u_rnsd_premul_plus (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coef_idx(coef_idx), .a(a),
    .out_valid(ov_p), .product(pr_p)
  );

  // R5: coefficient rule
  function automatic logic signed [B_W-1:0] coef(input int k);
    case (k)
      0: return 16'sh8000;
      1: return 16'sh7fff;
      2: return 16'sh0000;
      3: return 16'shffff;
      4: return 16'sh5555;
      5: return 16'shaaaa;
      default: return B_W'(k * 40503 + 12345);
    endcase
  endfunction

  task automatic check(input string req, input logic [P_W-1:0] got, input logic [P_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at falling edge, sample at next falling edge (one register)
  task automatic apply(input int k, input logic [A_W-1:0] av, input string req);
    logic [P_W-1:0] exp;
    in_valid = 1'b1;
    coef_idx = IDX_W'(k);
    a        = av;
    exp = P_W'(longint'($signed(av)) * longint'(coef(k)));
    @(negedge clk);
    check({req, " minus-set R6 R1"}, pr_m, exp);
    check({req, " plus-set R7 R1"},  pr_p, exp);
    check("R2 out_valid", {31'b0, ov_m & ov_p}, 32'd1);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [P_W-1:0] held;
    repeat (3) @(negedge clk);
    // R4
    check("R4 reset product minus", pr_m, '0);
    check("R4 reset product plus", pr_p, '0);
    check("R4 reset out_valid", {31'b0, ov_m | ov_p}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < DEPTH; k++) begin
      apply(k, 16'h8000, "R9 min operand");
      apply(k, 16'h7fff, "R9 max operand");
      apply(k, 16'h0000, "R9 zero operand");
      apply(k, 16'h0001, "R1 one");
      apply(k, 16'hffff, "R1 minus one");
      for (int r = 0; r < 200; r++) apply(k, A_W'($urandom), "R1 random");
    end
    // R10 R8: walk every single-bit operand through every entry
    for (int k = 0; k < DEPTH; k++)
      for (int b = 0; b < A_W; b++) apply(k, A_W'(1) << b, "R10 R8 bit walk");

    // R3: idle cycles with changing inputs keep the product
    apply(0, 16'h8000, "R9 extreme pair");
    held = pr_m;
    in_valid = 1'b0;
    for (int r = 0; r < 4; r++) begin
      coef_idx = IDX_W'(r + 1);
      a        = A_W'($urandom);
      @(negedge clk);
      check("R3 hold minus", pr_m, held);
      check("R3 hold plus", pr_p, held);
      check("R2 idle out_valid", {31'b0, ov_m | ov_p}, '0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule